// File: doc/BRIEF.md
# Bit Test-and-Modify Unit

This unit carries out single-bit test operations on a 64-bit operand. It can only test the bit, or test it and then set, clear or invert it. The operand is either a register value passed in on the operation port or a quadword in memory. The bit position comes either from a register-sized offset or from a small immediate. The bit as it stood before the change is returned as the carry flag. A flag-update mask marks carry as the only flag the operation touches.

For register targets the modified value comes back on the result port one cycle after the operation is accepted. A write-enable tells the register file whether to store it. For memory targets with a register offset, the offset can point well outside the base quadword. The unit treats the offset as a signed bit number and moves the base by whole quadwords, with an optional truncation to a 32-bit address space. Memory targets then run as a read followed, for the modifying forms, by a write to the same address. A simple request/acknowledge port carries both accesses. The unit takes no new operation until the current one has delivered its result.

Top module: `bit_tmod_unit`

## Requirements
- R1: For a register bit offset, only bits [5:0] of `bit_off` select the bit; the upper bits have no effect on which bit is tested or changed.
- R2: For an immediate offset (`op_use_imm`=1), only bits [5:0] of `imm_off` select the bit, and a memory access goes to `base_addr` exactly as given.
- R3: `op_code` 2'b00 tests only, 2'b01 forces the bit to 1, 2'b10 forces it to 0, 2'b11 inverts it; every other bit is left as it was. For a register target, `res_value` is the updated value and `res_reg_we` is 1 only for codes other than 2'b00.
- R4: `res_carry` equals the selected bit of the operand before any change, in every form.
- R5: For a memory target with a register offset, the access address is `base_addr` plus 8 times (`bit_off` with bits [5:0] cleared, divided as a signed number by 64), modulo 2^64.
- R6: When `op_addr64` is 0, the computed register-offset memory address has bits [63:32] forced to 0.
- R7: A modifying memory form issues exactly one read and then exactly one write (`mem_we`=1) to the same address, with `mem_wdata` the updated quadword. A test-only memory form issues exactly one read and no write. `res_value` of a memory form is the written quadword, or the read quadword for the test form.
- R8: While `res_valid` is 1, `res_flag_mask` is 6'b000001 (bit 0 is carry); all other flag bits are marked unchanged.
- R9: `op_ready` is 0 from the cycle after an operation is accepted until the result has been delivered. `op_valid` asserted in that time is ignored and starts no further memory access.
- R10: `res_valid` is a single-cycle pulse. For a register target it rises in the cycle right after acceptance.
- R11: After a synchronous reset `op_ready` is 1 and `res_valid`, `mem_req` and `res_reg_we` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Unit idle, operation accepted when valid |
| op_code | input | 2 | 00 test, 01 set, 10 clear, 11 invert |
| op_is_mem | input | 1 | 1 selects memory target, 0 register target |
| op_use_imm | input | 1 | 1 takes the bit number from the immediate |
| op_addr64 | input | 1 | 1 keeps a full 64-bit address, 0 truncates to 32 bits |
| reg_value | input | 64 | Register operand |
| bit_off | input | 64 | Register bit offset, signed |
| imm_off | input | 8 | Immediate bit offset |
| base_addr | input | 64 | Quadword base address of the memory operand |
| res_valid | output | 1 | Result pulse |
| res_value | output | 64 | Updated (or read) value |
| res_carry | output | 1 | Original value of the selected bit |
| res_reg_we | output | 1 | Register target should be written |
| res_flag_mask | output | 6 | Flags updated by the operation |
| mem_req | output | 1 | Memory request, one cycle per access |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 64 | Access address |
| mem_wdata | output | 64 | Write data |
| mem_ack | input | 1 | Read data valid or write complete |
| mem_rdata | input | 64 | Read data |

## Verification
The bench sweeps every bit position under all four codes with junk in the offset's upper bits and in the immediate's top two bits. A unit that used too many offset bits would pick the wrong bit or shift out zero. Memory runs use negative offsets, offsets just past a quadword boundary and the most negative offset, where a logical shift or an unsigned divide would move the address the wrong way. They also use bases that cross 4 GiB with the 32-bit address mode, where missing truncation shows in the upper address bits. Runs that hold `op_valid` high through a busy memory sequence and vary the acknowledge latency expose a unit that re-accepts, writes back on a test, or writes to an address other than the one it read.

// File: rtl/btm_pkg.sv
package btm_pkg;
  typedef enum logic [1:0] {
    BOP_TEST = 2'b00,
    BOP_SET  = 2'b01,
    BOP_CLR  = 2'b10,
    BOP_FLIP = 2'b11
  } bop_e;

  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_RDREQ  = 3'd1,
    S_RDWAIT = 3'd2,
    S_WRREQ  = 3'd3,
    S_WRWAIT = 3'd4,
    S_DONE   = 3'd5
  } st_e;

  localparam int FLAG_W    = 6;
  localparam int CARRY_POS = 0;
endpackage

// File: rtl/btm_addr_gen.sv
module btm_addr_gen #(
  parameter int W        = 64,
  parameter int NARROW_W = 32
) (
  input  logic                  use_imm,
  input  logic                  addr_full,
  input  logic [W-1:0]          base,
  input  logic [W-1:0]          off,
  input  logic [$clog2(W)-1:0]  imm_idx,
  output logic [$clog2(W)-1:0]  idx,
  output logic [W-1:0]          addr
);
  localparam int IDX_W   = $clog2(W);
  localparam int BYTE_SH = $clog2(W / 8);

  logic signed [W-1:0] disp;
  logic        [W-1:0] moved;
  logic        [W-1:0] narrowed;

  // Arithmetic shift floors toward minus infinity; with the low index bits
  // discarded this equals the exact signed division by the word width.
  assign disp  = $signed(off) >>> IDX_W;
  assign moved = base + (W'(disp) << BYTE_SH);

  generate
    if (W > NARROW_W) begin : g_trunc
      assign narrowed = {{(W - NARROW_W){1'b0}}, moved[NARROW_W-1:0]};
    end else begin : g_notrunc
      assign narrowed = moved;
    end
  endgenerate

  always_comb begin
    if (use_imm) begin
      idx  = imm_idx;
      addr = base;
    end else begin
      idx  = off[IDX_W-1:0];
      addr = addr_full ? moved : narrowed;
    end
  end
endmodule

// File: rtl/btm_bit_alu.sv
module btm_bit_alu
  import btm_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [W-1:0]         val,
  input  logic [$clog2(W)-1:0] idx,
  input  bop_e                 op,
  output logic [W-1:0]         new_val,
  output logic                 old_bit
);
  logic [W-1:0] sel;

  generate
    for (genvar b = 0; b < W; b++) begin : g_dec
      assign sel[b] = (idx == b[$clog2(W)-1:0]);
    end
  endgenerate

  assign old_bit = |(val & sel);

  always_comb begin
    case (op)
      BOP_SET:  new_val = val | sel;
      BOP_CLR:  new_val = val & ~sel;
      BOP_FLIP: new_val = val ^ sel;
      default:  new_val = val;
    endcase
  end
endmodule

// File: rtl/bit_tmod_unit.sv
module bit_tmod_unit
  import btm_pkg::*;
#(
  parameter int W     = 64,
  parameter int IMM_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  output logic              op_ready,
  input  logic [1:0]        op_code,
  input  logic              op_is_mem,
  input  logic              op_use_imm,
  input  logic              op_addr64,
  input  logic [W-1:0]      reg_value,
  input  logic [W-1:0]      bit_off,
  input  logic [IMM_W-1:0]  imm_off,
  input  logic [W-1:0]      base_addr,
  output logic              res_valid,
  output logic [W-1:0]      res_value,
  output logic              res_carry,
  output logic              res_reg_we,
  output logic [FLAG_W-1:0] res_flag_mask,
  output logic              mem_req,
  output logic              mem_we,
  output logic [W-1:0]      mem_addr,
  output logic [W-1:0]      mem_wdata,
  input  logic              mem_ack,
  input  logic [W-1:0]      mem_rdata
);
  localparam int IDX_W = $clog2(W);

  st_e              st;
  bop_e             op_q;
  logic             mem_q;
  logic [IDX_W-1:0] idx_q;
  logic [W-1:0]     addr_q;
  logic [W-1:0]     data_q;
  logic             carry_q;

  logic [IDX_W-1:0] gen_idx;
  logic [W-1:0]     gen_addr;
  logic [W-1:0]     alu_val;
  logic [IDX_W-1:0] alu_idx;
  bop_e             alu_op;
  logic [W-1:0]     alu_new;
  logic             alu_bit;
  logic             in_idle;
  logic             unused_imm_hi;

  assign unused_imm_hi = ^imm_off[IMM_W-1:IDX_W];

  btm_addr_gen #(.W(W)) i_agen (
    .use_imm   (op_use_imm),
    .addr_full (op_addr64),
    .base      (base_addr),
    .off       (bit_off),
    .imm_idx   (imm_off[IDX_W-1:0]),
    .idx       (gen_idx),
    .addr      (gen_addr)
  );

  assign in_idle = (st == S_IDLE);
  assign alu_val = in_idle ? reg_value : mem_rdata;
  assign alu_idx = in_idle ? gen_idx : idx_q;
  assign alu_op  = in_idle ? bop_e'(op_code) : op_q;

  btm_bit_alu #(.W(W)) i_alu (
    .val     (alu_val),
    .idx     (alu_idx),
    .op      (alu_op),
    .new_val (alu_new),
    .old_bit (alu_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      op_q    <= BOP_TEST;
      mem_q   <= 1'b0;
      idx_q   <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      carry_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          if (op_valid) begin
            op_q   <= bop_e'(op_code);
            mem_q  <= op_is_mem;
            idx_q  <= gen_idx;
            addr_q <= gen_addr;
            if (op_is_mem) begin
              st <= S_RDREQ;
            end else begin
              data_q  <= alu_new;
              carry_q <= alu_bit;
              st      <= S_DONE;
            end
          end
        end
        S_RDREQ: st <= S_RDWAIT;
        S_RDWAIT: begin
          if (mem_ack) begin
            data_q  <= alu_new;
            carry_q <= alu_bit;
            st      <= (op_q == BOP_TEST) ? S_DONE : S_WRREQ;
          end
        end
        S_WRREQ: st <= S_WRWAIT;
        S_WRWAIT: begin
          if (mem_ack) st <= S_DONE;
        end
        S_DONE:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign op_ready      = in_idle;
  assign mem_req       = (st == S_RDREQ) || (st == S_WRREQ);
  assign mem_we        = (st == S_WRREQ);
  assign mem_addr      = addr_q;
  assign mem_wdata     = data_q;
  assign res_valid     = (st == S_DONE);
  assign res_value     = data_q;
  assign res_carry     = carry_q;
  assign res_reg_we    = (st == S_DONE) && !mem_q && (op_q != BOP_TEST);
  assign res_flag_mask = (st == S_DONE) ? FLAG_W'(1 << CARRY_POS) : '0;
endmodule

// File: rtl/btm_checker.sv
module btm_checker #(
  parameter int W      = 64,
  parameter int FLAG_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              op_ready,
  input logic              res_valid,
  input logic              res_reg_we,
  input logic [FLAG_W-1:0] res_flag_mask,
  input logic              mem_req,
  input logic              mem_we,
  input logic [W-1:0]      mem_addr
);
  logic [W-1:0] rd_addr_q;

  always_ff @(posedge clk) begin
    if (rst) rd_addr_q <= '0;
    else if (mem_req && !mem_we) rd_addr_q <= mem_addr;
  end

  p_reset_idle_r11: assert property (@(posedge clk)
    $past(rst) |-> (op_ready && !res_valid && !mem_req && !res_reg_we));

  p_carry_mask_r8: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (res_flag_mask == FLAG_W'(1)));

  p_no_mask_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> (res_flag_mask == '0));

  p_busy_on_result_r9: assert property (@(posedge clk) disable iff (rst)
    (res_valid || mem_req) |-> !op_ready);

  p_result_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);

  p_req_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req);

  p_write_same_addr_r7: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> (mem_addr == rd_addr_q));

  p_we_only_req_r7: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_req);
endmodule

bind bit_tmod_unit btm_checker #(.W(W), .FLAG_W(btm_pkg::FLAG_W)) i_chk (
  .clk           (clk),
  .rst           (rst),
  .op_ready      (op_ready),
  .res_valid     (res_valid),
  .res_reg_we    (res_reg_we),
  .res_flag_mask (res_flag_mask),
  .mem_req       (mem_req),
  .mem_we        (mem_we),
  .mem_addr      (mem_addr)
);

// File: tb/test_bit_tmod_unit.sv
`timescale 1ns/1ps
module test_bit_tmod_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic        op_ready;
  logic [1:0]  op_code = 2'b00;
  logic        op_is_mem = 1'b0;
  logic        op_use_imm = 1'b0;
  logic        op_addr64 = 1'b1;
  logic [63:0] reg_value = '0;
  logic [63:0] bit_off = '0;
  logic [7:0]  imm_off = '0;
  logic [63:0] base_addr = '0;
  logic        res_valid;
  logic [63:0] res_value;
  logic        res_carry;
  logic        res_reg_we;
  logic [5:0]  res_flag_mask;
  logic        mem_req;
  logic        mem_we;
  logic [63:0] mem_addr;
  logic [63:0] mem_wdata;
  logic        mem_ack = 1'b0;
  logic [63:0] mem_rdata = '0;

  always #5 clk = ~clk;

  bit_tmod_unit i_bit_tmod_unit (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_ready(op_ready),
    .op_code(op_code), .op_is_mem(op_is_mem), .op_use_imm(op_use_imm),
    .op_addr64(op_addr64), .reg_value(reg_value), .bit_off(bit_off),
    .imm_off(imm_off), .base_addr(base_addr), .res_valid(res_valid),
    .res_value(res_value), .res_carry(res_carry), .res_reg_we(res_reg_we),
    .res_flag_mask(res_flag_mask), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  // memory responder
  int          lat_cfg = 0;
  bit          waiting = 0;
  int          cnt = 0;
  bit          pend_we = 0;
  logic [63:0] pend_addr = '0;
  int          rd_cnt = 0;
  int          wr_cnt = 0;
  logic [63:0] rd_addr = '0;
  logic [63:0] wr_addr = '0;
  logic [63:0] wr_data = '0;

  function automatic logic [63:0] mdat(input logic [63:0] a);
    return (a * 64'h9E37_79B9_7F4A_7C15) ^ 64'h0123_4567_89AB_CDEF;
  endfunction

  always @(negedge clk) begin
    mem_ack <= 1'b0;
    if (waiting) begin
      if (cnt == 0) begin
        mem_ack <= 1'b1;
        if (!pend_we) mem_rdata <= mdat(pend_addr);
        waiting <= 1'b0;
      end else begin
        cnt <= cnt - 1;
      end
    end else if (mem_req) begin
      waiting   <= 1'b1;
      cnt       <= lat_cfg;
      pend_we   <= mem_we;
      pend_addr <= mem_addr;
      if (mem_we) begin
        wr_cnt  <= wr_cnt + 1;
        wr_addr <= mem_addr;
        wr_data <= mem_wdata;
      end else begin
        rd_cnt  <= rd_cnt + 1;
        rd_addr <= mem_addr;
      end
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] code, input bit is_mem, input bit use_imm,
                        input bit a64, input logic [63:0] rv, input logic [63:0] off,
                        input logic [7:0] im, input logic [63:0] base,
                        input int lat, input bit junk);
    int          idx;
    longint      disp;
    logic [63:0] eaddr;
    logic [63:0] src;
    logic [63:0] nv;
    logic        orig;
    int          rd0;
    int          wr0;
    int          cyc;
    idx = use_imm ? int'(im % 64) : int'(off % 64);
    if (use_imm) begin
      eaddr = base;
    end else begin
      disp  = $signed(off & ~64'd63) / 64;
      eaddr = base + 64'(disp * 8);
      if (!a64) eaddr = eaddr & 64'h0000_0000_FFFF_FFFF;
    end
    src  = is_mem ? mdat(eaddr) : rv;
    orig = src[idx];
    nv   = src;
    if (code == 2'b01) nv[idx] = 1'b1;
    if (code == 2'b10) nv[idx] = 1'b0;
    if (code == 2'b11) nv[idx] = ~src[idx];
    lat_cfg = lat;
    @(negedge clk);
    while (!op_ready) @(negedge clk);
    rd0 = rd_cnt;
    wr0 = wr_cnt;
    op_valid = 1'b1; op_code = code; op_is_mem = is_mem; op_use_imm = use_imm;
    op_addr64 = a64; reg_value = rv; bit_off = off; imm_off = im; base_addr = base;
    @(negedge clk);
    chk("R9 busy after accept", 64'(op_ready), 64'd0);
    if (junk) begin
      op_code = ~code; bit_off = ~off; base_addr = ~base; op_is_mem = 1'b1; reg_value = ~rv;
    end else begin
      op_valid = 1'b0;
    end
    cyc = 1;
    while (!res_valid && cyc < 200) begin
      @(negedge clk);
      cyc++;
    end
    op_valid = 1'b0;
    if (!is_mem) chk("R10 register latency", 64'(cyc), 64'd1);
    chk("R4 carry", 64'(res_carry), 64'(orig));
    chk("R3 result value", res_value, nv);
    chk("R8 flag mask", 64'(res_flag_mask), 64'd1);
    chk("R3 register write enable", 64'(res_reg_we), 64'(!is_mem && code != 2'b00));
    @(negedge clk);
    chk("R10 result pulse", 64'(res_valid), 64'd0);
    @(negedge clk);
    if (is_mem) begin
      chk("R7 read count", 64'(rd_cnt - rd0), 64'd1);
      chk(use_imm ? "R2 read address" : (a64 ? "R5 read address" : "R6 read address"),
          rd_addr, eaddr);
      if (code == 2'b00) begin
        chk("R7 test writes nothing", 64'(wr_cnt - wr0), 64'd0);
      end else begin
        chk("R7 write count", 64'(wr_cnt - wr0), 64'd1);
        chk("R7 write address", wr_addr, eaddr);
        chk("R7 write data", wr_data, nv);
      end
    end else begin
      chk("R9 no memory access", 64'((rd_cnt - rd0) + (wr_cnt - wr0)), 64'd0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] offs [8];
    logic [63:0] bases [3];
    offs[0] = 64'd0;               offs[1] = 64'd63;
    offs[2] = 64'd69;              offs[3] = 64'hFFFF_FFFF_FFFF_FFFF;
    offs[4] = 64'hFFFF_FFFF_FFFF_FFC0; offs[5] = 64'hFFFF_FFFF_FFFF_FFBF;
    offs[6] = 64'h0000_0010_0000_0123; offs[7] = 64'h8000_0000_0000_0007;
    bases[0] = 64'h0000_0000_0000_1000;
    bases[1] = 64'h0000_0000_FFFF_FFF8;
    bases[2] = 64'h1234_5678_0000_0040;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R11 reset state
    chk("R11 ready after reset", 64'(op_ready), 64'd1);
    chk("R11 no result after reset", 64'(res_valid), 64'd0);
    chk("R11 no request after reset", 64'(mem_req), 64'd0);
    chk("R11 no register write after reset", 64'(res_reg_we), 64'd0);

    // R1 R3 R4: register target, every bit, every code, junk above the index
    for (int c = 0; c < 4; c++)
      for (int b = 0; b < 64; b++) begin
        run_op(2'(c), 1'b0, 1'b0, 1'b1, 64'hA5C3_0F96_5A3C_F069,
               {58'h2AB_CDEF_0123_4567, 6'(b)}, 8'h00, '0, 0, 1'b0);
        run_op(2'(c), 1'b0, 1'b0, 1'b1, ~(64'd1 << b) ^ 64'h0000_FFFF_0000_0000,
               64'(b) | 64'hFFFF_FFFF_FFFF_FFC0, 8'hFF, '0, 0, (b % 5) == 0);
      end

    // R2: immediate offset, top immediate bits set
    for (int c = 0; c < 4; c++)
      for (int b = 0; b < 64; b++)
        run_op(2'(c), 1'b0, 1'b1, 1'b0, 64'h0F0F_3333_5555_FFFF,
               64'hDEAD_BEEF_DEAD_BEEF, {2'(b % 4), 6'(b)}, '0, 0, 1'b0);

    // R5 R6 R7: memory with register offsets, both address sizes
    for (int c = 0; c < 4; c++)
      for (int o = 0; o < 8; o++)
        for (int a = 0; a < 2; a++)
          run_op(2'(c), 1'b1, 1'b0, a[0], '0, offs[o], 8'h00,
                 bases[(o + a) % 3], (o + c) % 4, (o % 3) == 1);

    // R2 R7: memory with immediate offsets, base used as given even in 32-bit mode
    for (int c = 0; c < 4; c++)
      for (int b = 0; b < 64; b += 7)
        run_op(2'(c), 1'b1, 1'b1, 1'b0, '0, 64'hFFFF_0000_FFFF_0000,
               {2'b11, 6'(b)}, bases[2], b % 3, (b % 2) == 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule